// File: doc/BRIEF.md
# Per-Processor Interrupt Presentation Controller

This block is the stage of a two-level interrupt controller that sits next to one processor. It decides which interrupt is currently offered to that processor, drives the processor's interrupt line, and reports back to the source stage when a source has to be retried. Priorities are eight bits wide, and a numerically lower value wins. A value of 0xFF means "off". The block keeps a 32-bit presentation word. Its top byte is the processor's current priority and its low 24 bits are the source number now on offer, where zero means none. It also keeps the priority of the offered source and the priority of a built-in inter-processor interrupt (IPI). The IPI always carries source number 2.

The source stage offers deliveries (a source number and a priority). The processor side issues one operation per cycle: write the current priority, write the IPI priority, accept the offered interrupt, or signal end-of-interrupt (EOI). A source that cannot be presented, or that is displaced by a more favoured one, is handed back on the reject pulse. The resend pulse asks the source stage to offer its held-back sources again. The EOI pulse forwards the completed source number.

Interface rules: at most one processor-side operation is active in a cycle. A delivery may share a cycle only with an accept. Delivered source numbers are never zero.

Top module: `icp_presenter`

## Requirements
- R1: After reset the interrupt line is low, the presentation word reads 0, and both the offered-source priority and the IPI priority are 0xFF.
- R2: A delivery whose priority is below the current priority, made while nothing is on offer, is latched (source number in bits 23:0, its priority kept) and raises the interrupt line at the next clock edge.
- R3: A delivery is handed back on the reject pulse, with its own source number, when its priority is equal to or above the current priority, or when a source is on offer whose priority is less than or equal to it. The state is left unchanged.
- R4: A delivery more favoured than the source on offer replaces it, and the displaced source number goes out on the reject pulse.
- R5: An accept returns the presentation word (current priority in bits 31:24, offered source in bits 23:0) in the same cycle. At the next edge the line drops, the current priority takes the offered-source priority, the source field clears, and the offered-source priority returns to 0xFF.
- R6: A delivery in the same cycle as an accept is judged against the state the accept leaves behind.
- R7: Writing an IPI priority below the current priority offers source 2 at that priority, displacing (and rejecting) a less favoured offered source. The offer is not made when the source on offer has a priority less than or equal to the new IPI priority. A write that is not below the current priority only stores the value.
- R8: Writing a lower current priority withdraws an offered source whose priority is not below the new value: the line drops, the offered-source priority returns to 0xFF, and the source is rejected. A source more favoured than the new value stays on offer.
- R9: Writing an equal or higher current priority while nothing is on offer produces a resend pulse, and first offers the IPI if the IPI priority is below the new current priority.
- R10: An EOI write loads bits 31:24 of the written word into the current priority and emits an EOI pulse carrying bits 23:0. If nothing is on offer, a resend follows in the same cycle, as in R9.
- R11: Reject, resend and EOI pulses appear in the cycle after the edge that consumed the stimulus, and each lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dlv_valid | input | 1 | Delivery from the source stage is present |
| dlv_source | input | 24 | Source number of the delivery (nonzero) |
| dlv_prio | input | 8 | Priority of the delivery |
| cur_wr | input | 1 | Write the current processor priority |
| cur_wr_prio | input | 8 | New current priority |
| ipi_wr | input | 1 | Write the IPI priority |
| ipi_wr_prio | input | 8 | New IPI priority |
| accept | input | 1 | Read-and-acknowledge strobe |
| accept_word | output | 32 | Presentation word, valid in the accept cycle |
| eoi_wr | input | 1 | End-of-interrupt write |
| eoi_wr_word | input | 32 | EOI word: new current priority in bits 31:24, finished source in bits 23:0 |
| irq | output | 1 | Interrupt line to the processor |
| reject_valid | output | 1 | Reject pulse to the source stage |
| reject_source | output | 24 | Source number being handed back |
| resend_valid | output | 1 | Resend request pulse to the source stage |
| eoi_valid | output | 1 | EOI pulse to the source stage |
| eoi_source | output | 24 | Source number being completed |

## Verification
The accept word is combinational and is due in the same cycle as the strobe. The interrupt line and the reject, resend and EOI pulses are due one edge after the stimulus. The bench drives inputs just after a rising edge and compares everything at the following falling edge. At that point the accept word is checked against the reference state before the edge, and the line and pulses against the reference results of the previous edge. The reference model is advanced once per cycle, so every output is compared on every cycle at the time it is due.

// File: rtl/icp_pkg.sv
package icp_pkg;

    parameter int PRIO_W = 8;
    parameter int SRC_W  = 24;
    localparam int WORD_W = PRIO_W + SRC_W;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [SRC_W-1:0]  src_t;

    localparam prio_t PRIO_OFF = '1;
    localparam src_t  SRC_NONE = '0;

    // Architectural state of one presentation server
    typedef struct packed {
        prio_t cur;        // current processor priority
        src_t  pend_src;   // source on offer, zero = none
        prio_t pend_prio;  // priority of the source on offer
        prio_t ipi_prio;   // inter-processor interrupt priority
        logic  line;       // interrupt line level
    } pres_state_t;

    // Result of trying to put a source on offer
    typedef struct packed {
        pres_state_t st;
        logic        refused;
        logic        bumped;
        src_t        bumped_src;
    } offer_t;

    // Pulses sent back to the source stage
    typedef struct packed {
        logic reject;
        src_t reject_src;
        logic resend;
        logic eoi;
        src_t eoi_src;
    } notify_t;

    function automatic offer_t offer(pres_state_t s, src_t src, prio_t prio);
        offer_t r;
        r.st         = s;
        r.refused    = 1'b0;
        r.bumped     = 1'b0;
        r.bumped_src = SRC_NONE;
        if ((prio >= s.cur) || ((s.pend_src != SRC_NONE) && (s.pend_prio <= prio))) begin
            r.refused = 1'b1;
        end else begin
            if (s.pend_src != SRC_NONE) begin
                r.bumped     = 1'b1;
                r.bumped_src = s.pend_src;
            end
            r.st.pend_src  = src;
            r.st.pend_prio = prio;
            r.st.line      = 1'b1;
        end
        return r;
    endfunction

    // Resend path: re-offer the IPI when it beats the current priority
    function automatic pres_state_t reoffer_ipi(pres_state_t s, src_t ipi_id);
        offer_t o;
        o = offer(s, ipi_id, s.ipi_prio);
        if (s.ipi_prio < s.cur) begin
            return o.st;
        end
        return s;
    endfunction

endpackage

// File: rtl/icp_cpu_ops.sv
module icp_cpu_ops
    import icp_pkg::*;
#(
    parameter src_t IPI_ID = 24'd2
) (
    input  pres_state_t          cur_st,
    input  logic                 set_cur_vld,
    input  prio_t                set_cur_val,
    input  logic                 set_ipi_vld,
    input  prio_t                set_ipi_val,
    input  logic                 eoi_vld,
    input  logic [WORD_W-1:0]    eoi_word,
    input  logic                 accept_vld,
    output pres_state_t          next_st,
    output notify_t              note
);

    always_comb begin
        pres_state_t s;
        offer_t      o;
        s    = cur_st;
        o    = '0;
        note = '0;
        if (accept_vld) begin
            s.cur       = cur_st.pend_prio;
            s.pend_src  = SRC_NONE;
            s.pend_prio = PRIO_OFF;
            s.line      = 1'b0;
        end else if (set_cur_vld) begin
            s.cur = set_cur_val;
            if (set_cur_val < cur_st.cur) begin
                if ((cur_st.pend_src != SRC_NONE) && (set_cur_val <= cur_st.pend_prio)) begin
                    note.reject     = 1'b1;
                    note.reject_src = cur_st.pend_src;
                    s.pend_src      = SRC_NONE;
                    s.pend_prio     = PRIO_OFF;
                    s.line          = 1'b0;
                end
            end else if (cur_st.pend_src == SRC_NONE) begin
                s           = reoffer_ipi(s, IPI_ID);
                note.resend = 1'b1;
            end
        end else if (set_ipi_vld) begin
            s.ipi_prio = set_ipi_val;
            if (set_ipi_val < cur_st.cur) begin
                o               = offer(s, IPI_ID, set_ipi_val);
                s               = o.st;
                note.reject     = o.bumped;
                note.reject_src = o.bumped_src;
            end
        end else if (eoi_vld) begin
            s.cur        = eoi_word[WORD_W-1:SRC_W];
            note.eoi     = 1'b1;
            note.eoi_src = eoi_word[SRC_W-1:0];
            if (cur_st.pend_src == SRC_NONE) begin
                s           = reoffer_ipi(s, IPI_ID);
                note.resend = 1'b1;
            end
        end
        next_st = s;
    end

endmodule

// File: rtl/icp_deliver.sv
module icp_deliver
    import icp_pkg::*;
(
    input  pres_state_t in_st,
    input  logic        dlv_vld,
    input  src_t        dlv_src,
    input  prio_t       dlv_prio,
    output pres_state_t out_st,
    output logic        rej,
    output src_t        rej_src
);

    always_comb begin
        offer_t o;
        o       = offer(in_st, dlv_src, dlv_prio);
        out_st  = in_st;
        rej     = 1'b0;
        rej_src = SRC_NONE;
        if (dlv_vld) begin
            out_st = o.st;
            if (o.refused) begin
                rej     = 1'b1;
                rej_src = dlv_src;
            end else if (o.bumped) begin
                rej     = 1'b1;
                rej_src = o.bumped_src;
            end
        end
    end

endmodule

// File: rtl/icp_presenter.sv
module icp_presenter
    import icp_pkg::*;
#(
    parameter src_t IPI_SOURCE = 24'd2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dlv_valid,
    input  logic [SRC_W-1:0]  dlv_source,
    input  logic [PRIO_W-1:0] dlv_prio,
    input  logic              cur_wr,
    input  logic [PRIO_W-1:0] cur_wr_prio,
    input  logic              ipi_wr,
    input  logic [PRIO_W-1:0] ipi_wr_prio,
    input  logic              accept,
    output logic [WORD_W-1:0] accept_word,
    input  logic              eoi_wr,
    input  logic [WORD_W-1:0] eoi_wr_word,
    output logic              irq,
    output logic              reject_valid,
    output logic [SRC_W-1:0]  reject_source,
    output logic              resend_valid,
    output logic              eoi_valid,
    output logic [SRC_W-1:0]  eoi_source
);

    pres_state_t state_q, after_cpu, after_dlv;
    notify_t     cpu_note, note_d, note_q;
    logic        dlv_rej;
    src_t        dlv_rej_src;

    // Stage 1: processor-side operation (accept, priority writes, EOI)
    icp_cpu_ops #(.IPI_ID(IPI_SOURCE)) u_cpu_ops (
        .cur_st      (state_q),
        .set_cur_vld (cur_wr),
        .set_cur_val (cur_wr_prio),
        .set_ipi_vld (ipi_wr),
        .set_ipi_val (ipi_wr_prio),
        .eoi_vld     (eoi_wr),
        .eoi_word    (eoi_wr_word),
        .accept_vld  (accept),
        .next_st     (after_cpu),
        .note        (cpu_note)
    );

    // Stage 2: delivery judged against the post-operation state
    icp_deliver u_deliver (
        .in_st    (after_cpu),
        .dlv_vld  (dlv_valid),
        .dlv_src  (dlv_source),
        .dlv_prio (dlv_prio),
        .out_st   (after_dlv),
        .rej      (dlv_rej),
        .rej_src  (dlv_rej_src)
    );

    always_comb begin
        note_d = cpu_note;
        if (dlv_rej) begin
            note_d.reject     = 1'b1;
            note_d.reject_src = dlv_rej_src;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.cur       <= '0;
            state_q.pend_src  <= SRC_NONE;
            state_q.pend_prio <= PRIO_OFF;
            state_q.ipi_prio  <= PRIO_OFF;
            state_q.line      <= 1'b0;
            note_q            <= '0;
        end else begin
            state_q <= after_dlv;
            note_q  <= note_d;
        end
    end

    assign accept_word   = {state_q.cur, state_q.pend_src};
    assign irq           = state_q.line;
    assign reject_valid  = note_q.reject;
    assign reject_source = note_q.reject_src;
    assign resend_valid  = note_q.resend;
    assign eoi_valid     = note_q.eoi;
    assign eoi_source    = note_q.eoi_src;

    // Interface rules that the single reject port relies on
    assert_op_contract_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cur_wr, ipi_wr, eoi_wr, accept}) && !(dlv_valid && (cur_wr || ipi_wr || eoi_wr))
        && (!dlv_valid || (dlv_source != SRC_NONE)));

    assert_line_tracks_offer_R2: assert property (@(posedge clk) disable iff (rst)
        irq == (accept_word[SRC_W-1:0] != SRC_NONE));

    assert_idle_prio_off_R1: assert property (@(posedge clk) disable iff (rst)
        (state_q.pend_src == SRC_NONE) |-> (state_q.pend_prio == PRIO_OFF));

    assert_accept_lowers_R5: assert property (@(posedge clk) disable iff (rst)
        (accept && !dlv_valid) |=> (!irq && (accept_word[SRC_W-1:0] == SRC_NONE)));

    assert_eoi_echo_R10: assert property (@(posedge clk) disable iff (rst)
        eoi_wr |=> (eoi_valid && (eoi_source == $past(eoi_wr_word[SRC_W-1:0]))));

    assert_withdraw_R8: assert property (@(posedge clk) disable iff (rst)
        (cur_wr && (cur_wr_prio < state_q.cur) && (state_q.pend_src != SRC_NONE)
         && (cur_wr_prio <= state_q.pend_prio))
        |=> (!irq && reject_valid && (reject_source == $past(state_q.pend_src))));

    assert_resend_cause_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(resend_valid) |-> ($past(cur_wr) || $past(eoi_wr)));

endmodule

// File: tb/test_icp_presenter.sv
module test_icp_presenter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dlv_valid = 1'b0;
    logic [23:0] dlv_source = '0;
    logic [7:0]  dlv_prio = '0;
    logic        cur_wr = 1'b0;
    logic [7:0]  cur_wr_prio = '0;
    logic        ipi_wr = 1'b0;
    logic [7:0]  ipi_wr_prio = '0;
    logic        accept = 1'b0;
    logic [31:0] accept_word;
    logic        eoi_wr = 1'b0;
    logic [31:0] eoi_wr_word = '0;
    logic        irq, reject_valid, resend_valid, eoi_valid;
    logic [23:0] reject_source, eoi_source;

    always #10 clk = ~clk;

    icp_presenter i_icp_presenter (
        .clk(clk), .rst(rst),
        .dlv_valid(dlv_valid), .dlv_source(dlv_source), .dlv_prio(dlv_prio),
        .cur_wr(cur_wr), .cur_wr_prio(cur_wr_prio),
        .ipi_wr(ipi_wr), .ipi_wr_prio(ipi_wr_prio),
        .accept(accept), .accept_word(accept_word),
        .eoi_wr(eoi_wr), .eoi_wr_word(eoi_wr_word),
        .irq(irq), .reject_valid(reject_valid), .reject_source(reject_source),
        .resend_valid(resend_valid), .eoi_valid(eoi_valid), .eoi_source(eoi_source)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string cur_req = "R1";

    // Behavioural reference
    int m_cppr, m_xisr, m_pend, m_mfrr, m_irq;
    int e_rej, e_rej_src, e_res, e_eoi, e_eoi_src;

    task automatic chk(string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic m_offer(int src, int prio, bit from_dlv);
        if (prio >= m_cppr || (m_xisr != 0 && m_pend <= prio)) begin
            if (from_dlv) begin e_rej = 1; e_rej_src = src; end
        end else begin
            if (m_xisr != 0) begin e_rej = 1; e_rej_src = m_xisr; end
            m_xisr = src; m_pend = prio; m_irq = 1;
        end
    endtask

    task automatic m_resend();
        if (m_mfrr < m_cppr) m_offer(2, m_mfrr, 0);
        e_res = 1;
    endtask

    task automatic model_update();
        e_rej = 0; e_res = 0; e_eoi = 0;
        if (accept) begin
            m_cppr = m_pend; m_xisr = 0; m_pend = 255; m_irq = 0;
        end else if (cur_wr) begin
            int oldc = m_cppr;
            m_cppr = cur_wr_prio;
            if (m_cppr < oldc) begin
                if (m_xisr != 0 && m_cppr <= m_pend) begin
                    e_rej = 1; e_rej_src = m_xisr;
                    m_xisr = 0; m_pend = 255; m_irq = 0;
                end
            end else if (m_xisr == 0) m_resend();
        end else if (ipi_wr) begin
            m_mfrr = ipi_wr_prio;
            if (m_mfrr < m_cppr) m_offer(2, m_mfrr, 0);
        end else if (eoi_wr) begin
            m_cppr = eoi_wr_word[31:24];
            e_eoi = 1; e_eoi_src = eoi_wr_word[23:0];
            if (m_xisr == 0) m_resend();
        end
        if (dlv_valid) m_offer(dlv_source, dlv_prio, 1);
    endtask

    task automatic cyc();
        @(negedge clk);
        chk("irq line", irq, m_irq);
        chk("reject pulse R11", reject_valid, e_rej);
        if (e_rej != 0) chk("reject source", reject_source, e_rej_src);
        chk("resend pulse R11", resend_valid, e_res);
        chk("eoi pulse R11", eoi_valid, e_eoi);
        if (e_eoi != 0) chk("eoi source", eoi_source, e_eoi_src);
        chk("accept word", accept_word, (longint'(m_cppr) << 24) | m_xisr);
        model_update();
        @(posedge clk);
        #2;
        dlv_valid = 0; cur_wr = 0; ipi_wr = 0; accept = 0; eoi_wr = 0;
    endtask

    task automatic deliver(int src, int prio);
        dlv_valid = 1; dlv_source = src[23:0]; dlv_prio = prio[7:0];
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        m_cppr = 0; m_xisr = 0; m_pend = 255; m_mfrr = 255; m_irq = 0;
        e_rej = 0; e_rej_src = 0; e_res = 0; e_eoi = 0; e_eoi_src = 0;
        repeat (3) @(posedge clk);
        #2 rst = 0;

        cur_req = "R1"; cyc();
        // R9: raise current priority with nothing on offer, IPI off -> plain resend
        cur_req = "R9"; cur_wr = 1; cur_wr_prio = 8'hFF; cyc();
        cur_req = "R2"; deliver(24'h10, 5); cyc();
        cur_req = "R3"; deliver(24'h11, 5); cyc();
        cur_req = "R3"; deliver(24'h13, 8'hFF); cyc();
        cur_req = "R4"; deliver(24'h12, 3); cyc();
        cur_req = "R5"; accept = 1; cyc();
        cur_req = "R3"; deliver(24'h14, 3); cyc();
        cur_req = "R10"; eoi_wr = 1; eoi_wr_word = 32'hFF00_0012; cyc();
        cur_req = "R7"; ipi_wr = 1; ipi_wr_prio = 8'h40; cyc();
        cur_req = "R7"; ipi_wr = 1; ipi_wr_prio = 8'h50; cyc();
        cur_req = "R7"; ipi_wr = 1; ipi_wr_prio = 8'h20; cyc();
        cur_req = "R8"; cur_wr = 1; cur_wr_prio = 8'h20; cyc();
        cur_req = "R9"; cur_wr = 1; cur_wr_prio = 8'h30; cyc();
        cur_req = "R5"; accept = 1; cyc();
        cur_req = "R7"; ipi_wr = 1; ipi_wr_prio = 8'hFF; cyc();
        cur_req = "R10"; eoi_wr = 1; eoi_wr_word = 32'hFF00_0002; cyc();
        cur_req = "R2"; deliver(24'h33, 8'h10); cyc();
        cur_req = "R6"; accept = 1; deliver(24'h34, 8'h08); cyc();
        cur_req = "R6"; accept = 1; deliver(24'h35, 8'h08); cyc();
        cur_req = "R10"; eoi_wr = 1; eoi_wr_word = 32'h8000_0034; cyc();
        cur_req = "R2"; deliver(24'h40, 8'h05); cyc();
        cur_req = "R8"; cur_wr = 1; cur_wr_prio = 8'h20; cyc();
        cur_req = "R11"; cyc();
        cur_req = "R11"; cyc();

        // Mixed legal traffic
        cur_req = "R4";
        for (int i = 0; i < 600; i++) begin
            int op = $urandom_range(0, 6);
            case (op)
                1: deliver($urandom_range(1, 20), $urandom_range(0, 255));
                2: begin cur_wr = 1; cur_wr_prio = 8'($urandom_range(0, 255)); end
                3: begin ipi_wr = 1; ipi_wr_prio = 8'($urandom_range(0, 255)); end
                4: begin eoi_wr = 1; eoi_wr_word = {8'($urandom_range(0, 255)), 24'($urandom_range(0, 20))}; end
                5: accept = 1;
                6: begin accept = 1; deliver($urandom_range(1, 20), $urandom_range(0, 255)); end
                default: ;
            endcase
            cyc();
        end
        cur_req = "R11"; cyc();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule